// File: doc/BRIEF.md
# Transactional Read-Set Conflict Tracker

This block sits beside a 4-way set-associative L1 data cache. It records which cache lines a running hardware transaction has read, and it ends that transaction the moment one of those lines leaves the L1. It keeps one mark bit and one line address per cache entry. It holds no data, performs no tag lookup and does not choose victims. The way for each fill comes from the external replacement logic, and the set index is taken from the low bits of the line address.

Conflicts are resolved in favour of the requester. An external invalidation, whether a coherence snoop from another agent or a back-invalidation forced by displacement in the shared L2, is acknowledged in the same cycle. If the invalidation hits a marked line, the transaction dies. Both kinds of invalidation are reported as coherence failures, so a single-threaded program can still see them. A lost line is reported to software through a one-cycle abort pulse with a 12-bit cause word. The bit positions of the cause word are fixed because software decodes them.

Top module: `tmrs_tracker`

## Requirements
- R1: After reset `tx_active`, `abort_pulse` and `abort_cause` are 0. A `tx_begin` while idle sets `tx_active` at the next clock edge, and a `tx_begin` while active has no effect.
- R2: A translated load (`ld_xlate_ok`=1) inside a transaction marks the line at set `ld_addr[SET_W-1:0]`, way `ld_way`. Reloading the same address into the same way does not abort. A `tx_commit` with no conflict in the same cycle clears `tx_active` without an abort pulse.
- R3: An eviction (`ev_valid`) of a marked entry inside a transaction gives, one cycle later, a single-cycle `abort_pulse` with `abort_cause` bit 7 (0x080, load loss) and `tx_active`=0.
- R4: A translated fill into a way that holds a marked line with a different address aborts with cause 0x080. This case covers a fifth distinct line entering a set whose four ways are all marked.
- R5: An invalidation whose `inv_addr` matches a marked line aborts with cause bit 1 (0x002, coherence). Snoops and L2 back-invalidations are treated the same way.
- R6: A load inside a transaction with `ld_xlate_ok`=0 aborts with cause 0x090 (bits 7 and 4: load loss plus precise exception).
- R7: Every commit and every abort clears all marks in one cycle, so lines marked by an earlier transaction never cause a later abort.
- R8: Evictions and invalidations of unmarked entries have no effect. Loads, evictions, invalidations and `tx_abort` outside a transaction also have no effect: no pulse, no state change.
- R9: `tx_abort` inside a transaction aborts with cause bit 2 (0x004, software trap).
- R10: A conflict in the same cycle as `tx_commit` aborts instead of committing. Causes that occur in the same cycle are ORed into one cause word.
- R11: `snoop_ack` is high in exactly the cycles where `inv_valid` is high, whether or not a marked line is hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_begin | input | 1 | Start a transaction |
| tx_commit | input | 1 | Commit the running transaction |
| tx_abort | input | 1 | Software-requested abort |
| ld_valid | input | 1 | Transactional load fill |
| ld_addr | input | ADDR_W | Line address of the fill; low SET_W bits are the set |
| ld_way | input | WAY_W | Way picked by replacement for the fill |
| ld_xlate_ok | input | 1 | Data translation was available for the load |
| ev_valid | input | 1 | Eviction caused by the core's own activity |
| ev_set | input | SET_W | Set of the evicted entry |
| ev_way | input | WAY_W | Way of the evicted entry |
| inv_valid | input | 1 | External invalidation (snoop or L2 back-invalidation) |
| inv_addr | input | ADDR_W | Line address being invalidated |
| snoop_ack | output | 1 | Same-cycle grant of the invalidation |
| tx_active | output | 1 | A transaction is running |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_cause | output | 12 | Cause bits, valid with abort_pulse, 0 otherwise |

## Verification
The bench builds the tracker with four sets, four ways and 8-bit line addresses. With only four sets, a handful of addresses (0x10, 0x20, 0x30, 0x40, 0x50) all land in set 0. This makes it easy to fill every way of one set with marked lines and then force a fifth fill into that set. The narrow addresses also let the bench reuse a line address from a finished transaction after a commit or an abort. Same-cycle collisions are driven directly: a commit together with a snoop hit, and an eviction together with an invalidation.

// File: rtl/tmrs_pkg.sv
// Package: shared constants of the transactional read-set tracker.
// The cause bit positions are fixed because software decodes them.
package tmrs_pkg;
    localparam int CAUSE_W = 12;
    localparam logic [CAUSE_W-1:0] CAUSE_COH  = 12'h002;
    localparam logic [CAUSE_W-1:0] CAUSE_TRAP = 12'h004;
    localparam logic [CAUSE_W-1:0] CAUSE_PREC = 12'h010;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD = 12'h080;
endpackage

// File: rtl/tmrs_mark_array.sv
// Module: tmrs_mark_array
// Holds one transactional mark bit and one line address per L1 entry.
// Assumes at most one mark write per cycle; clear_all takes priority
// over a write in the same cycle.
module tmrs_mark_array #(
    parameter int SETS   = 64,
    parameter int WAYS   = 4,
    parameter int ADDR_W = 26,
    parameter int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
    parameter int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     clear_all,
    input  logic                                     wr_en,
    input  logic [SET_W-1:0]                         wr_set,
    input  logic [WAY_W-1:0]                         wr_way,
    input  logic [ADDR_W-1:0]                        wr_addr,
    output logic [SETS-1:0][WAYS-1:0]                marks,
    output logic [SETS-1:0][WAYS-1:0][ADDR_W-1:0]    tags
);
    for (genvar gs = 0; gs < SETS; gs++) begin : g_set
        localparam logic [SET_W-1:0] SIDX = SET_W'(gs);
        for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
            localparam logic [WAY_W-1:0] WIDX = WAY_W'(gw);
            logic hit_wr;
            assign hit_wr = wr_en && (wr_set == SIDX) && (wr_way == WIDX);

            // Set this entry's mark on a fill; drop it on flash clear.
            always_ff @(posedge clk) begin
                if (!rst_n)          marks[gs][gw] <= 1'b0;
                else if (clear_all)  marks[gs][gw] <= 1'b0;
                else if (hit_wr)     marks[gs][gw] <= 1'b1;
            end

            // Capture the line address that belongs to the mark.
            always_ff @(posedge clk) begin
                if (!rst_n)                   tags[gs][gw] <= '0;
                else if (hit_wr && !clear_all) tags[gs][gw] <= wr_addr;
            end
        end
    end

    // R7
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (marks == '0));
    // R8
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_all && !wr_en) |=> $stable(marks));
endmodule

// File: rtl/tmrs_conflict_detect.sv
// Module: tmrs_conflict_detect
// Combinational detection of read-set losses for one cycle's events.
// Assumes the set index of a line is its low SET_W address bits and
// that all outputs are qualified by tx_active.
module tmrs_conflict_detect #(
    parameter int SETS   = 64,
    parameter int WAYS   = 4,
    parameter int ADDR_W = 26,
    parameter int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
    parameter int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                                  tx_active,
    input  logic [SETS-1:0][WAYS-1:0]             marks,
    input  logic [SETS-1:0][WAYS-1:0][ADDR_W-1:0] tags,
    input  logic                                  ld_valid,
    input  logic [ADDR_W-1:0]                     ld_addr,
    input  logic [WAY_W-1:0]                      ld_way,
    input  logic                                  ld_xlate_ok,
    input  logic                                  ev_valid,
    input  logic [SET_W-1:0]                      ev_set,
    input  logic [WAY_W-1:0]                      ev_way,
    input  logic                                  inv_valid,
    input  logic [ADDR_W-1:0]                     inv_addr,
    output logic                                  ld_displace,
    output logic                                  ld_xlate_fail,
    output logic                                  ev_hit,
    output logic                                  inv_hit,
    output logic                                  mark_req
);
    logic [SET_W-1:0] ld_set;
    logic [SET_W-1:0] inv_set;
    logic             ld_ok;

    assign ld_set  = ld_addr[SET_W-1:0];
    assign inv_set = inv_addr[SET_W-1:0];
    assign ld_ok   = tx_active && ld_valid && ld_xlate_ok;

    // Classify the load: displaces another marked line, lacks translation, or marks.
    always_comb begin
        ld_displace   = ld_ok && marks[ld_set][ld_way]
                        && (tags[ld_set][ld_way] != ld_addr);
        ld_xlate_fail = tx_active && ld_valid && !ld_xlate_ok;
        mark_req      = ld_ok && !ld_displace;
    end

    // Own eviction hits the read set if the victim entry is marked.
    always_comb begin
        ev_hit = tx_active && ev_valid && marks[ev_set][ev_way];
    end

    // External invalidation hits if any way of its set holds that marked line.
    always_comb begin
        inv_hit = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (marks[inv_set][w] && (tags[inv_set][w] == inv_addr))
                inv_hit = 1'b1;
        end
        inv_hit = inv_hit && tx_active && inv_valid;
    end
endmodule

// File: rtl/tmrs_abort_ctrl.sv
// Module: tmrs_abort_ctrl
// Transaction state, abort pulse and cause word. Assumes conflict inputs
// are already qualified by the running transaction; software abort is not.
module tmrs_abort_ctrl
    import tmrs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_begin,
    input  logic               tx_commit,
    input  logic               tx_abort,
    input  logic               ld_displace,
    input  logic               ld_xlate_fail,
    input  logic               ev_hit,
    input  logic               inv_hit,
    output logic               tx_active,
    output logic               clear_all,
    output logic               abort_pulse,
    output logic [CAUSE_W-1:0] abort_cause
);
    logic [CAUSE_W-1:0] cause_nxt;
    logic               kill;

    // Merge all causes raised this cycle into one word.
    always_comb begin
        cause_nxt = '0;
        if (ld_displace || ev_hit) cause_nxt = cause_nxt | CAUSE_LOAD;
        if (ld_xlate_fail)         cause_nxt = cause_nxt | CAUSE_LOAD | CAUSE_PREC;
        if (inv_hit)               cause_nxt = cause_nxt | CAUSE_COH;
        if (tx_active && tx_abort) cause_nxt = cause_nxt | CAUSE_TRAP;
        kill      = tx_active && (cause_nxt != '0);
        clear_all = tx_active && (kill || tx_commit);
    end

    // Track the transaction and raise a one-cycle pulse on abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_active   <= 1'b0;
            abort_pulse <= 1'b0;
            abort_cause <= '0;
        end else begin
            abort_pulse <= kill;
            abort_cause <= kill ? cause_nxt : '0;
            if (tx_active)     tx_active <= !(kill || tx_commit);
            else if (tx_begin) tx_active <= 1'b1;
        end
    end

    // R1
    pulse_ends_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> !tx_active);
    // R10
    pulse_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (abort_cause != '0));
    // R8
    idle_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |=> !abort_pulse);
endmodule

// File: rtl/tmrs_tracker.sv
// Module: tmrs_tracker (top)
// Read-set conflict tracker for a set-associative L1 under hardware
// transactions. Requester wins: invalidations are granted at once.
// Assumes the replacement logic supplies the fill way and that
// ADDR_W >= SET_W.
module tmrs_tracker
    import tmrs_pkg::*;
#(
    parameter int SETS   = 64,
    parameter int WAYS   = 4,
    parameter int ADDR_W = 26,
    parameter int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
    parameter int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_begin,
    input  logic               tx_commit,
    input  logic               tx_abort,
    input  logic               ld_valid,
    input  logic [ADDR_W-1:0]  ld_addr,
    input  logic [WAY_W-1:0]   ld_way,
    input  logic               ld_xlate_ok,
    input  logic               ev_valid,
    input  logic [SET_W-1:0]   ev_set,
    input  logic [WAY_W-1:0]   ev_way,
    input  logic               inv_valid,
    input  logic [ADDR_W-1:0]  inv_addr,
    output logic               snoop_ack,
    output logic               tx_active,
    output logic               abort_pulse,
    output logic [CAUSE_W-1:0] abort_cause
);
    logic [SETS-1:0][WAYS-1:0]             marks;
    logic [SETS-1:0][WAYS-1:0][ADDR_W-1:0] tags;
    logic ld_displace, ld_xlate_fail, ev_hit, inv_hit, mark_req, clear_all;

    // Grant every invalidation in its own cycle; the requester never waits.
    assign snoop_ack = inv_valid;

    tmrs_mark_array #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W),
                      .SET_W(SET_W), .WAY_W(WAY_W)) u_marks (
        .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
        .wr_en(mark_req), .wr_set(ld_addr[SET_W-1:0]), .wr_way(ld_way),
        .wr_addr(ld_addr), .marks(marks), .tags(tags)
    );

    tmrs_conflict_detect #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W),
                           .SET_W(SET_W), .WAY_W(WAY_W)) u_detect (
        .tx_active(tx_active), .marks(marks), .tags(tags),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_way(ld_way),
        .ld_xlate_ok(ld_xlate_ok), .ev_valid(ev_valid), .ev_set(ev_set),
        .ev_way(ev_way), .inv_valid(inv_valid), .inv_addr(inv_addr),
        .ld_displace(ld_displace), .ld_xlate_fail(ld_xlate_fail),
        .ev_hit(ev_hit), .inv_hit(inv_hit), .mark_req(mark_req)
    );

    tmrs_abort_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit),
        .tx_abort(tx_abort), .ld_displace(ld_displace),
        .ld_xlate_fail(ld_xlate_fail), .ev_hit(ev_hit), .inv_hit(inv_hit),
        .tx_active(tx_active), .clear_all(clear_all),
        .abort_pulse(abort_pulse), .abort_cause(abort_cause)
    );

    // R3
    evict_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hit |=> (abort_pulse && abort_cause[7]));
    // R5
    snoop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_hit |=> (abort_pulse && abort_cause[1]));
    // R6
    xlate_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_xlate_fail |=> (abort_pulse && abort_cause[7] && abort_cause[4]));
endmodule

// File: tb/tb_tmrs_tracker.sv
module tb_tmrs_tracker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_begin = 0, tx_commit = 0, tx_abort = 0;
    logic ld_valid = 0, ld_xlate_ok = 0, ev_valid = 0, inv_valid = 0;
    logic [7:0] ld_addr = '0, inv_addr = '0;
    logic [1:0] ld_way = '0, ev_set = '0, ev_way = '0;
    logic snoop_ack, tx_active, abort_pulse;
    logic [11:0] abort_cause;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        logic        pulse;
        logic [11:0] cause;
        logic        act;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    tmrs_tracker #(.SETS(4), .WAYS(4), .ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit),
        .tx_abort(tx_abort), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_way(ld_way), .ld_xlate_ok(ld_xlate_ok), .ev_valid(ev_valid),
        .ev_set(ev_set), .ev_way(ev_way), .inv_valid(inv_valid),
        .inv_addr(inv_addr), .snoop_ack(snoop_ack), .tx_active(tx_active),
        .abort_pulse(abort_pulse), .abort_cause(abort_cause)
    );

    // Monitor: after each edge, compare outputs with the oldest expectation.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (abort_pulse !== e.pulse || abort_cause !== e.cause || tx_active !== e.act) begin
                n_bad++;
                $display("FAIL %s: got pulse=%b cause=%h act=%b, expected pulse=%b cause=%h act=%b",
                         e.tag, abort_pulse, abort_cause, tx_active, e.pulse, e.cause, e.act);
            end
        end
    end

    // Driver: apply one cycle of stimulus and queue the outcome expected after the edge.
    task automatic step(input logic b, input logic c, input logic a,
                        input logic lv, input logic [7:0] la, input logic [1:0] lw,
                        input logic xok, input logic ev, input logic [1:0] es,
                        input logic [1:0] ew, input logic iv, input logic [7:0] ia,
                        input logic ep, input logic [11:0] ec, input logic ea,
                        input string tag);
        exp_t e;
        @(negedge clk);
        tx_begin = b; tx_commit = c; tx_abort = a;
        ld_valid = lv; ld_addr = la; ld_way = lw; ld_xlate_ok = xok;
        ev_valid = ev; ev_set = es; ev_way = ew;
        inv_valid = iv; inv_addr = ia;
        e.pulse = ep; e.cause = ec; e.act = ea; e.tag = tag;
        q.push_back(e);
        #1;
        n_chk++;
        if (snoop_ack !== iv) begin
            n_bad++;
            $display("FAIL R11 ack (%s): got %b expected %b", tag, snoop_ack, iv);
        end
    endtask

    task automatic idle(input logic ea, input string tag);
        step(0,0,0, 0,8'h00,2'd0,0, 0,2'd0,2'd0, 0,8'h00, 0,12'h000,ea, tag);
    endtask

    task automatic begin_tx(input string tag);
        step(1,0,0, 0,8'h00,2'd0,0, 0,2'd0,2'd0, 0,8'h00, 0,12'h000,1, tag);
    endtask

    task automatic load(input logic [7:0] a, input logic [1:0] w, input string tag);
        step(0,0,0, 1,a,w,1, 0,2'd0,2'd0, 0,8'h00, 0,12'h000,1, tag);
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        n_chk++;
        if (tx_active !== 0 || abort_pulse !== 0 || abort_cause !== 12'h000) begin
            n_bad++;
            $display("FAIL R1 reset: got act=%b pulse=%b cause=%h expected 0/0/000",
                     tx_active, abort_pulse, abort_cause);
        end
        // R1 begin; begin again while active is ignored
        begin_tx("R1 begin");
        begin_tx("R1 begin while active");
        // R2 mark four lines of set 0, reload one without abort
        load(8'h10, 2'd0, "R2 load 10");
        load(8'h10, 2'd0, "R2 reload same line");
        load(8'h20, 2'd1, "R2 load 20");
        load(8'h30, 2'd2, "R2 load 30");
        load(8'h40, 2'd3, "R2 load 40");
        // R8 unmarked eviction and invalidation miss do nothing; R11 ack on a miss
        step(0,0,0, 0,8'h00,2'd0,0, 1,2'd1,2'd0, 0,8'h00, 0,12'h000,1, "R8 evict unmarked");
        step(0,0,0, 0,8'h00,2'd0,0, 0,2'd0,2'd0, 1,8'h50, 0,12'h000,1, "R8 R11 inv miss");
        // R4 fifth line into a full marked set
        step(0,0,0, 1,8'h50,2'd2,1, 0,2'd0,2'd0, 0,8'h00, 1,12'h080,0, "R4 fifth line");
        idle(0, "R3 pulse lasts one cycle");
        // R8 events outside a transaction have no effect
        step(0,0,1, 1,8'h60,2'd0,0, 1,2'd0,2'd0, 1,8'h10, 0,12'h000,0, "R8 events while idle");
        idle(0, "R8 still idle");
        // R7 marks cleared by the abort: old line 0x20 no longer tracked
        begin_tx("R7 new tx");
        step(0,0,0, 0,8'h00,2'd0,0, 1,2'd0,2'd1, 1,8'h20, 0,12'h000,1, "R7 stale after abort");
        // R2 commit without conflict
        load(8'h11, 2'd0, "R2 load 11");
        step(0,1,0, 0,8'h00,2'd0,0, 0,2'd0,2'd0, 0,8'h00, 0,12'h000,0, "R2 commit");
        // R7 marks cleared by commit
        begin_tx("R7 tx after commit");
        step(0,0,0, 0,8'h00,2'd0,0, 0,2'd0,2'd0, 1,8'h11, 0,12'h000,1, "R7 stale after commit");
        // R5 invalidation hit aborts with coherence
        load(8'h22, 2'd1, "R5 load 22");
        step(0,0,0, 0,8'h00,2'd0,0, 0,2'd0,2'd0, 1,8'h22, 1,12'h002,0, "R5 snoop hit");
        // R3 own eviction of a marked line
        begin_tx("R3 begin");
        load(8'h33, 2'd3, "R3 load 33");
        step(0,0,0, 0,8'h00,2'd0,0, 1,2'd3,2'd3, 0,8'h00, 1,12'h080,0, "R3 evict marked");
        // R6 load without translation
        begin_tx("R6 begin");
        step(0,0,0, 1,8'h07,2'd1,0, 0,2'd0,2'd0, 0,8'h00, 1,12'h090,0, "R6 no translation");
        // R9 software abort
        begin_tx("R9 begin");
        step(0,0,1, 0,8'h00,2'd0,0, 0,2'd0,2'd0, 0,8'h00, 1,12'h004,0, "R9 sw abort");
        // R10 conflict beats commit
        begin_tx("R10 begin");
        load(8'h13, 2'd1, "R10 load 13");
        step(0,1,0, 0,8'h00,2'd0,0, 0,2'd0,2'd0, 1,8'h13, 1,12'h002,0, "R10 commit vs snoop");
        // R10 two causes in one cycle are ORed
        begin_tx("R10 begin 2");
        load(8'h44, 2'd0, "R10 load 44");
        step(0,0,0, 0,8'h00,2'd0,0, 1,2'd0,2'd0, 1,8'h44, 1,12'h082,0, "R10 evict+inv");
        idle(0, "R10 settle");
        idle(0, "R10 drain");
        report();
    end
endmodule